// File: doc/BRIEF.md
# Rotating-Priority Eight-Input Interrupt Controller

This block collects eight interrupt lines into a single interrupt output for a processor. It keeps three eight-bit state vectors: pending requests, requests currently being serviced, and a mask. A rotating priority base decides which pending line goes first. Software configures the controller by writing a short setup sequence through a byte-wide port with two addresses. It then steers the controller with command bytes that end or rotate service and with writes to the mask. A separate trigger register chooses, line by line, whether a request is edge-captured or follows the line level.

When the processor answers the interrupt, it pulses the acknowledge input. The controller marks the winning line as in service and returns an eight-bit vector one cycle later. If no line qualifies at that moment, the acknowledge is treated as spurious. A special nested mode lets a controller acting as a cascade master accept further requests on input 2 while input 2 is already in service.

Top module: `prio_intc`

## Requirements
- R1: A write to address 0 with bit 4 set starts setup. On that write the in-service bits, the mask, the rotation base, the vector base, both mode flags and all edge-captured requests go to zero. The trigger register keeps its contents.
- R2: On the cycle after the setup-start write, `int_out` is low. In that first word, bit 1 = 1 means single mode, which skips the third word. Bit 0 = 1 means a fourth word follows. Once setup is complete, further address-1 writes go to the mask.
- R3: The second setup word, with its low three bits forced to zero, becomes the vector base. One cycle after `ack`, `vec_vld` is high and `vec_out` equals the vector base plus the winning input number. If no input qualifies, `vec_out` is the vector base plus 7 and no state changes.
- R4: The priority of input i is (i − base) mod 8, where 0 is the highest. `int_out` rises only when an unmasked pending request has a strictly higher priority than every in-service input.
- R5: A command byte has bits 4 and 3 at zero, bits 7:5 as the code and bits 2:0 as the argument. Code 1 clears the in-service bit with the highest priority. Code 5 does the same and also sets the base to that input plus 1, modulo 8.
- R6: Code 3 clears the in-service bit named by the argument. Code 6 sets the base to the argument plus 1, modulo 8. Code 7 clears the named in-service bit and sets the base to the argument plus 1, modulo 8.
- R7: An acknowledge sets the winner's in-service bit. It clears the winner's request only when that input is edge-triggered. A level-triggered request stays pending.
- R8: `trig_wr` loads the trigger register, where bit i = 1 makes input i level-triggered. An edge input latches a request when its line is sampled low and then high on the next clock. A level input's request tracks the sampled line.
- R9: The fourth setup word enables special nested mode with bit 4 and master role with bit 2. When both are set, in-service bit 2 is left out of the current-priority comparison.
- R10: Bit i = 1 in the mask blocks input i from raising `int_out` or winning an acknowledge. A masked edge input still latches its request.
- R11: `int_out` is a register. It follows the request, mask and in-service state one cycle after that state changes. After reset, `int_out` and `vec_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register port write strobe |
| wr_addr | input | 1 | Register port address |
| wr_data | input | 8 | Register port write data |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_data | input | 8 | Trigger-mode bits, 1 = level |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_vld | output | 1 | Vector valid, one cycle after ack |
| vec_out | output | 8 | Returned interrupt vector |

## Verification
The hardest states to reach are those where in-service bits and a rotated base interact. Examples are a new request losing to an equal-priority in-service input, the nested-mode exception on input 2, and a level request that survives an acknowledge and then a full setup. Directed sequences build each of these states on purpose: they acknowledge first, then raise a competing line, then issue rotate commands. After that, a long seeded random mix of pulses, mask writes, acknowledges and all five command codes drives the base and the in-service vector through many combinations. A bench-side model predicts the output level and the vector at every step.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int unsigned NUM_IN = 8;
    parameter int unsigned DATA_W = 8;
    localparam int unsigned IDX_W = $clog2(NUM_IN);
    localparam int unsigned CASCADE_IN = 2;

    typedef logic [NUM_IN-1:0] line_vec_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SETUP_DONE,
        SETUP_W2,
        SETUP_W3,
        SETUP_W4
    } setup_st_e;

    typedef enum logic [2:0] {
        OP_NOP0     = 3'd0,
        OP_EOI_TOP  = 3'd1,
        OP_NOP2     = 3'd2,
        OP_EOI_NAME = 3'd3,
        OP_NOP4     = 3'd4,
        OP_ROT_TOP  = 3'd5,
        OP_SET_BASE = 3'd6,
        OP_ROT_NAME = 3'd7
    } op_code_e;

    typedef struct packed {
        logic found;
        idx_t idx;
    } pick_t;

    // Relative priority of a line against the rotation base; 0 is highest.
    function automatic idx_t rel_prio(idx_t line, idx_t base);
        return idx_t'(line - base);
    endfunction

    // Highest-priority set bit of v, scanning from the base upward.
    function automatic pick_t pick_top(line_vec_t v, idx_t base);
        pick_t r;
        idx_t  cand;
        r.found = 1'b0;
        r.idx   = '0;
        for (int p = NUM_IN - 1; p >= 0; p--) begin
            cand = idx_t'(base + idx_t'(p));
            if (v[cand]) begin
                r.found = 1'b1;
                r.idx   = cand;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/intc_capture.sv
module intc_capture
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t lines,
    input  line_vec_t level_sel,
    input  logic      init_clr,
    input  line_vec_t ack_clr,
    output line_vec_t irr
);
    line_vec_t samp_q;
    line_vec_t prev_q;
    line_vec_t rise;

    assign rise = samp_q & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
            prev_q <= '0;
            irr    <= '0;
        end else begin
            samp_q <= lines;
            prev_q <= samp_q;
            for (int i = 0; i < NUM_IN; i++) begin
                if (level_sel[i])
                    irr[i] <= samp_q[i];
                else
                    irr[i] <= (irr[i] & ~ack_clr[i] & ~init_clr) | rise[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_IN; g++) begin : g_bit_chk
        // R8
        level_track_chk: assert property (@(posedge clk) disable iff (rst)
            level_sel[g] |=> irr[g] == $past(samp_q[g]));
        // R8
        edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
            (!level_sel[g] && samp_q[g] && !prev_q[g]) |=> irr[g]);
    end
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
    import intc_pkg::*;
(
    input  line_vec_t irr,
    input  line_vec_t imr,
    input  line_vec_t isr,
    input  idx_t      base,
    input  logic      nested,
    input  logic      master,
    output pick_t     win
);
    line_vec_t isr_eff;
    pick_t     req;
    pick_t     cur;

    always_comb begin
        isr_eff = isr;
        if (nested && master)
            isr_eff[CASCADE_IN] = 1'b0;
    end

    assign req = pick_top(irr & ~imr, base);
    assign cur = pick_top(isr_eff, base);

    always_comb begin
        win.idx   = req.idx;
        win.found = req.found &&
                    (!cur.found || (rel_prio(req.idx, base) < rel_prio(cur.idx, base)));
    end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_addr,
    input  byte_t     wr_data,
    input  logic      ack,
    input  pick_t     win,
    output line_vec_t imr,
    output line_vec_t isr,
    output idx_t      base,
    output byte_t     vbase,
    output logic      nested,
    output logic      master,
    output logic      init_wr
);
    setup_st_e st_q;
    logic      single_q;
    logic      need4_q;
    logic      cmd_wr;
    logic      data_wr;
    op_code_e  op;
    idx_t      arg;
    pick_t     top_isr;
    line_vec_t isr_n;
    idx_t      base_n;

    assign init_wr = wr_en && !wr_addr && wr_data[4];
    assign cmd_wr  = wr_en && !wr_addr && !wr_data[4] && !wr_data[3];
    assign data_wr = wr_en && wr_addr;
    assign op      = op_code_e'(wr_data[7:5]);
    assign arg     = wr_data[IDX_W-1:0];
    assign top_isr = pick_top(isr, base);

    always_comb begin
        isr_n  = isr;
        base_n = base;
        if (ack && win.found)
            isr_n[win.idx] = 1'b1;
        if (cmd_wr) begin
            case (op)
                OP_EOI_TOP: begin
                    if (top_isr.found)
                        isr_n[top_isr.idx] = 1'b0;
                end
                OP_ROT_TOP: begin
                    if (top_isr.found) begin
                        isr_n[top_isr.idx] = 1'b0;
                        base_n = idx_t'(top_isr.idx + 1'b1);
                    end
                end
                OP_EOI_NAME: isr_n[arg] = 1'b0;
                OP_SET_BASE: base_n = idx_t'(arg + 1'b1);
                OP_ROT_NAME: begin
                    isr_n[arg] = 1'b0;
                    base_n = idx_t'(arg + 1'b1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SETUP_DONE;
            single_q <= 1'b0;
            need4_q  <= 1'b0;
            imr      <= '0;
            isr      <= '0;
            base     <= '0;
            vbase    <= '0;
            nested   <= 1'b0;
            master   <= 1'b0;
        end else if (init_wr) begin
            st_q     <= SETUP_W2;
            single_q <= wr_data[1];
            need4_q  <= wr_data[0];
            imr      <= '0;
            isr      <= '0;
            base     <= '0;
            vbase    <= '0;
            nested   <= 1'b0;
            master   <= 1'b0;
        end else begin
            isr  <= isr_n;
            base <= base_n;
            if (data_wr) begin
                case (st_q)
                    SETUP_DONE: imr <= wr_data[NUM_IN-1:0];
                    SETUP_W2: begin
                        vbase <= {wr_data[DATA_W-1:IDX_W], {IDX_W{1'b0}}};
                        if (single_q)
                            st_q <= need4_q ? SETUP_W4 : SETUP_DONE;
                        else
                            st_q <= SETUP_W3;
                    end
                    SETUP_W3: st_q <= need4_q ? SETUP_W4 : SETUP_DONE;
                    SETUP_W4: begin
                        nested <= wr_data[4];
                        master <= wr_data[2];
                        st_q   <= SETUP_DONE;
                    end
                    default: st_q <= SETUP_DONE;
                endcase
            end
        end
    end

    // R1
    setup_clear_chk: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> (isr == '0 && imr == '0 && base == '0 && vbase == '0 && !nested && !master));
    // R6
    set_base_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && op == OP_SET_BASE) |=> base == idx_t'($past(arg) + 1'b1));
    // R7
    ack_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && win.found && !cmd_wr && !init_wr) |=> isr[$past(win.idx)]);
    // R10
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && st_q == SETUP_DONE) |=> imr == $past(wr_data[NUM_IN-1:0]));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       trig_wr,
    input  logic [7:0] trig_data,
    input  logic       ack,
    output logic       int_out,
    output logic       vec_vld,
    output logic [7:0] vec_out
);
    line_vec_t trig_q;
    line_vec_t irr;
    line_vec_t imr;
    line_vec_t isr;
    line_vec_t ack_clr;
    idx_t      base;
    byte_t     vbase;
    logic      nested;
    logic      master;
    logic      init_wr;
    pick_t     win;

    always_ff @(posedge clk) begin
        if (rst)
            trig_q <= '0;
        else if (trig_wr)
            trig_q <= trig_data;
    end

    always_comb begin
        ack_clr = '0;
        if (ack && win.found)
            ack_clr[win.idx] = 1'b1;
    end

    intc_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .lines     (irq_in),
        .level_sel (trig_q),
        .init_clr  (init_wr),
        .ack_clr   (ack_clr),
        .irr       (irr)
    );

    intc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ack     (ack),
        .win     (win),
        .imr     (imr),
        .isr     (isr),
        .base    (base),
        .vbase   (vbase),
        .nested  (nested),
        .master  (master),
        .init_wr (init_wr)
    );

    intc_resolve u_resolve (
        .irr    (irr),
        .imr    (imr),
        .isr    (isr),
        .base   (base),
        .nested (nested),
        .master (master),
        .win    (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_out <= 1'b0;
            vec_vld <= 1'b0;
            vec_out <= '0;
        end else begin
            int_out <= init_wr ? 1'b0 : win.found;
            vec_vld <= ack;
            if (ack)
                vec_out <= vbase + DATA_W'(win.found ? win.idx : idx_t'(NUM_IN - 1));
        end
    end

    // R2
    setup_low_chk: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> !int_out);
    // R3
    vec_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> vec_vld);
    // R10
    masked_win_chk: assert property (@(posedge clk) disable iff (rst)
        win.found |-> !imr[win.idx]);
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       wr_en;
    logic       wr_addr;
    logic [7:0] wr_data;
    logic       trig_wr;
    logic [7:0] trig_data;
    logic       ack;
    logic       int_out;
    logic       vec_vld;
    logic [7:0] vec_out;

    int n_tests = 0;
    int n_fail  = 0;

    bit [7:0] m_irr, m_isr, m_imr, m_trig, m_vbase;
    int       m_base;
    bit       m_nested, m_master;

    always #5 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_wr(trig_wr), .trig_data(trig_data), .ack(ack),
        .int_out(int_out), .vec_vld(vec_vld), .vec_out(vec_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int m_top(input bit [7:0] v);
        for (int p = 0; p < 8; p++) begin
            if (v[(m_base + p) % 8]) return (m_base + p) % 8;
        end
        return -1;
    endfunction

    function automatic int m_win();
        bit [7:0] pend, busy;
        int r, c;
        pend = ((m_irr & ~m_trig) | (irq_in & m_trig)) & ~m_imr;
        busy = m_isr;
        if (m_nested && m_master) busy[2] = 1'b0;
        r = m_top(pend);
        if (r < 0) return -1;
        c = m_top(busy);
        if (c >= 0 && ((r - m_base + 8) % 8) >= ((c - m_base + 8) % 8)) return -1;
        return r;
    endfunction

    task automatic settle(input string req);
        tick(3);
        chk(req, int'(int_out), (m_win() >= 0) ? 1 : 0);
    endtask

    task automatic wr(input bit a, input bit [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic m_setup_clear();
        m_irr = 8'h00; m_isr = 8'h00; m_imr = 8'h00; m_base = 0;
        m_vbase = 8'h00; m_nested = 1'b0; m_master = 1'b0;
    endtask

    task automatic pulse(input int i, input string req);
        irq_in[i] = 1'b1;
        tick(1);
        irq_in[i] = 1'b0;
        if (!m_trig[i]) m_irr[i] = 1'b1;
        settle(req);
    endtask

    task automatic do_ack(input string req);
        int w;
        w = m_win();
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        chk({req, " valid"}, int'(vec_vld), 1);
        chk({req, " vector"}, int'(vec_out), int'(m_vbase) + ((w < 0) ? 7 : w));
        if (w >= 0) begin
            m_isr[w] = 1'b1;
            if (!m_trig[w]) m_irr[w] = 1'b0;
        end
        settle({req, " after ack"});
    endtask

    task automatic do_cmd(input bit [2:0] code, input bit [2:0] a, input string req);
        int t;
        wr(1'b0, {code, 2'b00, a});
        case (code)
            3'd1: begin t = m_top(m_isr); if (t >= 0) m_isr[t] = 1'b0; end
            3'd5: begin
                t = m_top(m_isr);
                if (t >= 0) begin m_isr[t] = 1'b0; m_base = (t + 1) % 8; end
            end
            3'd3: m_isr[a] = 1'b0;
            3'd6: m_base = (a + 1) % 8;
            3'd7: begin m_isr[a] = 1'b0; m_base = (a + 1) % 8; end
            default: ;
        endcase
        settle(req);
    endtask

    task automatic do_mask(input bit [7:0] m, input string req);
        wr(1'b1, m);
        m_imr = m;
        settle(req);
    endtask

    task automatic set_trig(input bit [7:0] t);
        trig_wr = 1'b1; trig_data = t;
        tick(1);
        trig_wr = 1'b0;
        m_trig = t;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        rst = 1'b1; irq_in = 8'h00; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
        trig_wr = 1'b0; trig_data = 8'h00; ack = 1'b0;
        m_trig = 8'h00;
        m_setup_clear();
        tick(3);
        // R11 reset state
        chk("R11 reset int_out", int'(int_out), 0);
        chk("R11 reset vec_vld", int'(vec_vld), 0);
        rst = 1'b0;
        tick(1);

        // R2 single mode with fourth word; R3 vector base low bits forced to zero
        wr(1'b0, 8'h13); m_setup_clear();
        wr(1'b1, 8'h47); m_vbase = 8'h40;
        wr(1'b1, 8'h01);
        pulse(3, "R8 edge capture line 3");
        chk("R11 int after pulse", int'(int_out), 1);
        do_ack("R3 ack line 3");
        // R4 lower priority blocked, higher passes
        pulse(5, "R4 lower than in-service");
        chk("R4 line 5 blocked", int'(int_out), 0);
        pulse(1, "R4 higher than in-service");
        chk("R4 line 1 passes", int'(int_out), 1);
        do_ack("R3 ack line 1");
        do_cmd(3'd1, 3'd0, "R5 top end clears line 1");
        do_cmd(3'd3, 3'd3, "R6 named end clears line 3");
        chk("R6 line 5 now wins", int'(int_out), 1);
        do_ack("R3 ack line 5");
        do_cmd(3'd3, 3'd5, "R6 named end line 5");

        // R10 mask
        do_mask(8'h04, "R10 mask line 2");
        pulse(2, "R10 masked pulse");
        chk("R10 masked line stays quiet", int'(int_out), 0);
        do_mask(8'h00, "R10 unmask latched request");
        chk("R10 latched request appears", int'(int_out), 1);
        do_ack("R3 ack line 2");
        do_cmd(3'd3, 3'd2, "R6 named end line 2");

        // R5/R6 rotation
        do_cmd(3'd6, 3'd4, "R6 set base to 5");
        pulse(2, "R4 rotated pulse 2");
        pulse(6, "R4 rotated pulse 6");
        do_ack("R4 rotated winner 6");
        chk("R4 winner line 6 vector", int'(vec_out), 8'h46);
        do_cmd(3'd5, 3'd0, "R5 rotate on end");
        do_ack("R5 after rotate ack 2");
        do_cmd(3'd7, 3'd2, "R6 named rotate 2");

        // R7/R8 level inputs
        set_trig(8'h10);
        irq_in[4] = 1'b1;
        settle("R8 level line 4 high");
        chk("R8 level raises int", int'(int_out), 1);
        do_ack("R7 ack level line 4");
        chk("R7 equal priority blocks", int'(int_out), 0);
        do_cmd(3'd3, 3'd4, "R7 level request stays pending");
        chk("R7 level still pending", int'(int_out), 1);
        do_ack("R7 ack level again");

        // R1/R2 setup clears in-service, keeps trigger, forces output low
        wr(1'b0, 8'h13); m_setup_clear();
        chk("R2 setup forces int low", int'(int_out), 0);
        wr(1'b1, 8'h20); m_vbase = 8'h20;
        wr(1'b1, 8'h01);
        settle("R1 trigger kept, in-service cleared");
        chk("R1 level line wins after setup", int'(int_out), 1);
        // R2 no fourth word: third write is the mask
        wr(1'b0, 8'h12); m_setup_clear();
        wr(1'b1, 8'h2B); m_vbase = 8'h28;
        wr(1'b1, 8'h10); m_imr = 8'h10;
        settle("R2 third write loads mask");
        chk("R2 mask blocks line 4", int'(int_out), 0);
        irq_in[4] = 1'b0;
        do_mask(8'h00, "R10 clear mask");
        do_ack("R3 spurious ack");
        chk("R3 spurious vector", int'(vec_out), 8'h2F);
        set_trig(8'h00);

        // R9 nested mode with master role
        wr(1'b0, 8'h11); m_setup_clear();
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h14); m_nested = 1'b1; m_master = 1'b1;
        pulse(2, "R9 first pulse 2");
        do_ack("R9 ack 2");
        pulse(2, "R9 nested second pulse 2");
        chk("R9 nested re-entry", int'(int_out), 1);
        do_ack("R9 ack 2 again");
        wr(1'b0, 8'h11); m_setup_clear();
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h04); m_master = 1'b1;
        pulse(2, "R9 plain first pulse 2");
        do_ack("R9 plain ack 2");
        pulse(2, "R9 plain second pulse 2");
        chk("R9 plain mode blocks re-entry", int'(int_out), 0);

        // Random phase, edge inputs
        seed_dummy = $urandom(32'h5EED_1234);
        wr(1'b0, 8'h13); m_setup_clear();
        wr(1'b1, 8'h80); m_vbase = 8'h80;
        wr(1'b1, 8'h00);
        tick(3);
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom % 7);
            case (sel)
                0, 1: pulse(int'($urandom % 8), "R4 random pulse");
                2: do_mask(8'($urandom & $urandom & $urandom), "R10 random mask");
                3, 4: do_ack("R3 random ack");
                default: begin
                    bit [2:0] codes [5];
                    codes = '{3'd1, 3'd3, 3'd5, 3'd6, 3'd7};
                    do_cmd(codes[$urandom % 5], 3'($urandom), "R6 random command");
                end
            endcase
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule